// File: doc/BRIEF.md
# Sector Write Protection Checker

This block sits beside a serial flash array controller and answers one question for every program or erase request: may it go ahead? It looks at the sector that a request lands in and weighs two independent protection schemes. The first is a region of power-of-two size, set by a three-bit protection level and a direction bit, that grows either downward from the highest sector or upward from sector 0. The second is a bank of per-sector volatile lock bits. Each sector also has a freeze bit. Once the freeze bit is set, that sector's lock and freeze bits cannot change again until reset.

The array is modelled as 128 sectors of 64 Kbytes. Each sector holds sixteen 4-Kbyte subsectors, which gives 2048 subsectors and 8 Mbytes in total. The sector number is always taken from the top seven bits of the 23-bit byte address. Requests can be a page program, a subsector erase, a sector erase or a whole-array erase.

Lock writes arrive on their own port, with the sector address and a two-bit value. A separate read port returns the stored bits of any sector. The verdict is registered: it appears one cycle after the request, together with a valid flag.

Top module: `sector_guard`

## Requirements
- R1: After reset, grant_valid and grant are 0 and every sector reads back lk_rd_data = 2'b00 (unlocked, not frozen).
- R2: With prot_level = 0 and the sector unlocked, a page (req_kind 0), subsector (1) or sector (2) request is granted.
- R3: With prot_from_bottom = 0, protection level L (1 to 7) protects the highest 2^L sectors. Level 7 covers all 128 sectors. A request whose sector, address bits [22:16], lies in that range is refused.
- R4: With prot_from_bottom = 1, level L protects sectors 0 to 2^L-1 instead.
- R5: A whole-array erase (req_kind 3) is granted exactly when prot_level = 0, whatever the lock bits hold.
- R6: A lock write (lkw_valid) to an unfrozen sector stores lkw_data (bit 0 = lock, bit 1 = freeze) for sector lkw_addr[22:16]. From the next cycle, lk_rd_data for lk_rd_addr[22:16] shows those bits in the same positions.
- R7: A page, subsector or sector request to a sector whose lock bit is set is refused.
- R8: A lock write to a sector whose freeze bit is set has no effect on that sector's bits until reset.
- R9: A subsector or page request is judged by the sector containing it: address bits [15:0] never change the verdict.
- R10: The verdict for a request sampled at a clock edge appears on grant, with grant_valid high, after that edge. grant is 0 whenever grant_valid is 0. A lock write in the same cycle as a request does not affect that request's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all lock state |
| req_valid | input | 1 | A program/erase request is present |
| req_kind | input | 2 | 0 page, 1 subsector, 2 sector, 3 whole array |
| req_addr | input | 23 | Byte address of the request |
| prot_level | input | 3 | Size code of the protected region |
| prot_from_bottom | input | 1 | 1: region starts at sector 0; 0: at the top sector |
| lkw_valid | input | 1 | Lock write strobe |
| lkw_addr | input | 23 | Any address inside the sector to be written |
| lkw_data | input | 2 | bit 0 lock, bit 1 freeze |
| lk_rd_addr | input | 23 | Any address inside the sector to read back |
| lk_rd_data | output | 2 | Stored bits of that sector, bit 0 lock, bit 1 freeze |
| grant_valid | output | 1 | A verdict is presented this cycle |
| grant | output | 1 | 1: request permitted, 0: refused |

## Verification
The hardest state to reach is a frozen sector receiving lock writes that try to change it. This must happen while other sectors stay writable and while the region settings change around it. The bench first freezes a locked sector and a separate unlocked sector, then tries to reverse both. After that it runs a long random phase with lock writes confined to sixteen sectors, so that frozen and unfrozen sectors get hit repeatedly. Last, it resets in mid-run to show the frozen state clears. A same-cycle lock write and request to one sector is forced by hand, to pin down which state the verdict uses.

// File: rtl/sg_pkg.sv
package sg_pkg;

    // Request kinds as they appear on req_kind.
    typedef enum logic [1:0] {
        KIND_PAGE   = 2'd0,
        KIND_SUBSEC = 2'd1,
        KIND_SECTOR = 2'd2,
        KIND_BULK   = 2'd3
    } req_kind_e;

    // Bit positions inside a lock write value and a lock readback value.
    localparam int LK_LOCK   = 0;
    localparam int LK_FREEZE = 1;

endpackage

// File: rtl/sg_region_decode.sv
module sg_region_decode #(
    parameter int SEC_W = 7,
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] level,
    input  logic             from_bottom,
    input  logic [SEC_W-1:0] sector,
    output logic             in_region
);
    localparam int NSEC = 1 << SEC_W;

    logic [SEC_W:0] span;
    logic [SEC_W:0] sec_ext;

    // Number of protected sectors: 0 for level 0, else 2^level, capped at the array.
    always_comb begin
        if (level == '0) begin
            span = '0;
        end else if (int'(level) >= SEC_W) begin
            span = (SEC_W+1)'(NSEC);
        end else begin
            span = (SEC_W+1)'(1) << level;
        end
    end

    assign sec_ext = {1'b0, sector};

    generate
        if (NSEC > 0) begin : g_cmp
            always_comb begin
                if (from_bottom) begin
                    in_region = sec_ext < span;
                end else begin
                    in_region = sec_ext >= ((SEC_W+1)'(NSEC) - span);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sg_lock_bank.sv
module sg_lock_bank import sg_pkg::*; #(
    parameter int SEC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEC_W-1:0] wr_sec,
    input  logic [1:0]       wr_bits,
    input  logic [SEC_W-1:0] chk_sec,
    output logic             chk_locked,
    input  logic [SEC_W-1:0] rd_sec,
    output logic [1:0]       rd_bits
);
    localparam int NSEC = 1 << SEC_W;

    typedef struct packed {
        logic [NSEC-1:0] lock;
        logic [NSEC-1:0] frz;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && !st_q.frz[wr_sec]) begin
            st_d.lock[wr_sec] = wr_bits[LK_LOCK];
            st_d.frz[wr_sec]  = wr_bits[LK_FREEZE];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chk_locked        = st_q.lock[chk_sec];
    assign rd_bits[LK_LOCK]   = st_q.lock[rd_sec];
    assign rd_bits[LK_FREEZE] = st_q.frz[rd_sec];

    // R8: a frozen sector keeps both bits until reset.
    generate
        for (genvar g = 0; g < NSEC; g++) begin : g_hold
            assert_frozen_hold_R8: assert property (
                @(posedge clk) disable iff (!rst_n)
                st_q.frz[g] |=> (st_q.frz[g] && $stable(st_q.lock[g]))
            );
        end
    endgenerate

    // R6: a write to an unfrozen sector lands in the next cycle.
    assert_write_lands_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_en && !st_q.frz[wr_sec]) |=>
            (st_q.lock[$past(wr_sec)] == $past(wr_bits[LK_LOCK]) &&
             st_q.frz[$past(wr_sec)]  == $past(wr_bits[LK_FREEZE]))
    );
endmodule

// File: rtl/sector_guard.sv
module sector_guard import sg_pkg::*; #(
    parameter int ADDR_W = 23,
    parameter int SEC_W  = 7,
    parameter int LVL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LVL_W-1:0]  prot_level,
    input  logic              prot_from_bottom,
    input  logic              lkw_valid,
    input  logic [ADDR_W-1:0] lkw_addr,
    input  logic [1:0]        lkw_data,
    input  logic [ADDR_W-1:0] lk_rd_addr,
    output logic [1:0]        lk_rd_data,
    output logic              grant_valid,
    output logic              grant
);
    typedef struct packed {
        logic gv;
        logic g;
    } verdict_t;

    verdict_t vd_d, vd_q;

    logic [SEC_W-1:0] req_sec, wr_sec, rd_sec;
    logic             in_region, lock_hit, is_bulk, allow;

    assign req_sec = req_addr[ADDR_W-1 -: SEC_W];
    assign wr_sec  = lkw_addr[ADDR_W-1 -: SEC_W];
    assign rd_sec  = lk_rd_addr[ADDR_W-1 -: SEC_W];

    sg_region_decode #(.SEC_W(SEC_W), .LVL_W(LVL_W)) u_region (
        .level       (prot_level),
        .from_bottom (prot_from_bottom),
        .sector      (req_sec),
        .in_region   (in_region)
    );

    sg_lock_bank #(.SEC_W(SEC_W)) u_locks (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (lkw_valid),
        .wr_sec     (wr_sec),
        .wr_bits    (lkw_data),
        .chk_sec    (req_sec),
        .chk_locked (lock_hit),
        .rd_sec     (rd_sec),
        .rd_bits    (lk_rd_data)
    );

    always_comb begin
        is_bulk = (req_kind == KIND_BULK);
        if (is_bulk) begin
            allow = (prot_level == '0);
        end else begin
            allow = !(in_region || lock_hit);
        end
        vd_d.gv = req_valid;
        vd_d.g  = req_valid && allow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q <= '0;
        end else begin
            vd_q <= vd_d;
        end
    end

    assign grant_valid = vd_q.gv;
    assign grant       = vd_q.g;

    assert_idle_no_grant_R10: assert property (
        @(posedge clk) disable iff (!rst_n) !grant_valid |-> !grant
    );

    assert_valid_follows_R10: assert property (
        @(posedge clk) disable iff (!rst_n) req_valid |=> grant_valid
    );

    assert_req_known_R10: assert property (
        @(posedge clk) disable iff (!rst_n)
        req_valid |-> !$isunknown({req_kind, req_addr, prot_level, prot_from_bottom})
    );

    assert_lkw_known_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        lkw_valid |-> !$isunknown({lkw_addr, lkw_data, lk_rd_addr})
    );

    assert_bulk_blocked_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == KIND_BULK && prot_level != '0) |=> !grant
    );

    assert_locked_reject_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != KIND_BULK && lk_rd_data[LK_LOCK] &&
         rd_sec == req_sec) |=> !grant
    );

    assert_full_region_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind != KIND_BULK && int'(prot_level) >= SEC_W) |=> !grant
    );
endmodule

// File: tb/sector_guard_tb.sv
module sector_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SEC_W  = 7;
    localparam int ADDR_W = 23;
    localparam int NSEC   = 128;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic [1:0]        req_kind;
    logic [ADDR_W-1:0] req_addr;
    logic [2:0]        prot_level;
    logic              prot_from_bottom;
    logic              lkw_valid;
    logic [ADDR_W-1:0] lkw_addr;
    logic [1:0]        lkw_data;
    logic [ADDR_W-1:0] lk_rd_addr;
    logic [1:0]        lk_rd_data;
    logic              grant_valid;
    logic              grant;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit mdl_lock [NSEC];
    bit mdl_frz  [NSEC];

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_guard u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .req_valid        (req_valid),
        .req_kind         (req_kind),
        .req_addr         (req_addr),
        .prot_level       (prot_level),
        .prot_from_bottom (prot_from_bottom),
        .lkw_valid        (lkw_valid),
        .lkw_addr         (lkw_addr),
        .lkw_data         (lkw_data),
        .lk_rd_addr       (lk_rd_addr),
        .lk_rd_data       (lk_rd_data),
        .grant_valid      (grant_valid),
        .grant            (grant)
    );

    function automatic bit exp_allow(int kind, int sec, int lvl, bit bot);
        int span;
        bit inreg;
        if (kind == 3) return (lvl == 0);
        span  = (lvl == 0) ? 0 : ((lvl >= SEC_W) ? NSEC : (1 << lvl));
        inreg = bot ? (sec < span) : (sec >= NSEC - span);
        return !inreg && !mdl_lock[sec];
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cycle(string tag, bit rv, int kind, int sec, int low, int lvl, bit bot,
                         bit wv, int wsec, bit wl, bit wf, int rsec);
        bit eg;
        req_valid        = rv;
        req_kind         = 2'(kind);
        req_addr         = {7'(sec), 16'(low)};
        prot_level       = 3'(lvl);
        prot_from_bottom = bot;
        lkw_valid        = wv;
        lkw_addr         = {7'(wsec), 16'h5a5a};
        lkw_data         = {wf, wl};
        lk_rd_addr       = {7'(rsec), 16'h0123};
        eg = rv ? exp_allow(kind, sec, lvl, bot) : 1'b0;
        @(posedge clk);
        if (wv && !mdl_frz[wsec]) begin
            mdl_lock[wsec] = wl;
            mdl_frz[wsec]  = wf;
        end
        @(negedge clk);
        check(tag, "grant_valid", int'(grant_valid), int'(rv));
        check(tag, "grant", int'(grant), int'(eg));
        check(tag, "lk_rd_data", int'(lk_rd_data), int'({mdl_frz[rsec], mdl_lock[rsec]}));
    endtask

    task automatic req(string tag, int kind, int sec, int low, int lvl, bit bot);
        cycle(tag, 1'b1, kind, sec, low, lvl, bot, 1'b0, 0, 1'b0, 1'b0, sec);
    endtask

    task automatic lkw(string tag, int sec, bit l, bit f);
        cycle(tag, 1'b0, 0, 0, 0, 0, 1'b0, 1'b1, sec, l, f, sec);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0; req_kind = '0; req_addr = '0; prot_level = '0;
        prot_from_bottom = 1'b0; lkw_valid = 1'b0; lkw_addr = '0; lkw_data = '0;
        lk_rd_addr = '0;
        repeat (2) @(negedge clk);
        foreach (mdl_lock[i]) begin
            mdl_lock[i] = 1'b0;
            mdl_frz[i]  = 1'b0;
        end
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int secs [23] = '{0, 1, 2, 3, 7, 8, 15, 16, 31, 32, 63, 64, 95, 96,
                          111, 112, 119, 120, 123, 124, 125, 126, 127};
        do_reset();
        // R1: reset state
        check("R1", "grant_valid", int'(grant_valid), 0);
        check("R1", "grant", int'(grant), 0);
        for (int s = 0; s < NSEC; s += 19)
            cycle("R1", 1'b0, 0, 0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, s);

        // R2: no region, unlocked sectors, all three non-bulk kinds
        for (int k = 0; k < 3; k++) begin
            req("R2", k, 0, 16'h0100, 0, 1'b0);
            req("R2", k, 64, 16'hff00, 0, 1'b1);
            req("R2", k, 127, 16'h0000, 0, 1'b0);
        end

        // R3 / R4: region sweep in both directions
        for (int b = 0; b < 2; b++)
            for (int l = 1; l < 8; l++)
                foreach (secs[i])
                    req(b ? "R4" : "R3", 0, secs[i], 16'h0040, l, b[0]);

        // R6 / R7: lock a sector, reject, neighbour fine, unlock
        lkw("R6", 5, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) req("R7", k, 5, 16'h2000, 0, 1'b0);
        req("R7", 0, 4, 16'h2000, 0, 1'b0);
        lkw("R6", 5, 1'b0, 1'b0);
        req("R7", 2, 5, 16'h0000, 0, 1'b0);

        // R9: subsector offsets inside a locked sector
        lkw("R6", 40, 1'b1, 1'b0);
        req("R9", 1, 40, 16'h0000, 0, 1'b0);
        req("R9", 1, 40, 16'h3000, 0, 1'b0);
        req("R9", 1, 40, 16'hf000, 0, 1'b0);
        req("R9", 0, 40, 16'hffff, 0, 1'b0);
        req("R9", 1, 41, 16'h0000, 0, 1'b0);

        // R8: frozen locked sector and frozen unlocked sector
        lkw("R8", 9, 1'b1, 1'b1);
        lkw("R8", 9, 1'b0, 1'b0);
        req("R8", 2, 9, 16'h0000, 0, 1'b0);
        lkw("R8", 10, 1'b0, 1'b1);
        lkw("R8", 10, 1'b1, 1'b0);
        req("R8", 2, 10, 16'h0000, 0, 1'b0);

        // R5: bulk erase with locks present
        req("R5", 3, 0, 0, 0, 1'b0);
        req("R5", 3, 9, 0, 0, 1'b1);
        for (int l = 1; l < 8; l++) begin
            req("R5", 3, 0, 0, l, 1'b0);
            req("R5", 3, 0, 0, l, 1'b1);
        end

        // R10: same-cycle lock write and request use the old state
        cycle("R10", 1'b1, 0, 20, 0, 0, 1'b0, 1'b1, 20, 1'b1, 1'b0, 20);
        req("R10", 0, 20, 0, 0, 1'b0);
        cycle("R10", 1'b0, 0, 20, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 20);

        // Random mix, lock writes confined to low sectors
        for (int n = 0; n < 3000; n++) begin
            int sel = int'($urandom_range(15, 0));
            int ws  = int'($urandom_range(15, 0));
            cycle("R6", $urandom_range(3, 0) != 0, int'($urandom_range(3, 0)),
                  (sel < 8) ? sel : int'($urandom_range(NSEC-1, 0)),
                  int'($urandom_range(16'hffff, 0)),
                  ($urandom_range(1, 0) != 0) ? 0 : int'($urandom_range(7, 0)),
                  $urandom_range(1, 0) != 0,
                  $urandom_range(2, 0) == 0, ws,
                  $urandom_range(1, 0) != 0, $urandom_range(15, 0) == 0,
                  int'($urandom_range(15, 0)));
        end

        // R1: reset in mid-run clears frozen state
        do_reset();
        check("R1", "grant_valid", int'(grant_valid), 0);
        cycle("R1", 1'b0, 0, 0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 1'b0, 9);
        req("R1", 2, 9, 0, 0, 1'b0);
        lkw("R1", 9, 1'b1, 1'b0);
        lkw("R1", 9, 1'b0, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule